// File: doc/BRIEF.md
# Bit-Shifted Bad-Block Marker Exchanger

On a NAND page laid out for an ECC engine, the byte that holds the factory bad-block marker rarely sits on a byte boundary of the corrected data view. It can start at any bit inside one data byte and run into the next byte. This unit swaps that shifted byte with one fixed byte of the spare buffer. After the swap, software always finds the marker in the spare slot, and the displaced user bits are kept safe in the marker's physical location. The unit runs once after decoding on a read and once before encoding on a write. The exchange is its own inverse, so the same operation serves both directions.

A caller supplies a byte offset and a bit offset and pulses `start`. The unit then does three reads over two synchronous RAM ports with one-cycle read latency: the low data byte, the high data byte, and the spare slot. It follows with three writes and a one-cycle `done`. All bits around the exchanged eight bits keep their values. The offset computation and the ECC codec are outside this unit.

Top module: `mark_swap_unit`

## Requirements
- R1: After reset, `busy`, `done`, `d_rd`, `d_wr`, `s_rd` and `s_wr` are all low.
- R2: The spare slot `MARK_SLOT` receives the data-view byte. Bit i of that byte equals bit (b+i) of the 16-bit word {data[off+1], data[off]}, where b is `bit_off`.
- R3: In data[off], bits at positions b and above become the old spare byte shifted left by b. Bits below b keep their values.
- R4: In data[off+1], bits below position b become the old spare byte shifted right by (8−b). Bits at b and above keep their values.
- R5: When b is 0, data[off+1] is never written and keeps its value. Its write slot in the sequence stays idle.
- R6: No data address other than off and off+1 is written, and no spare address other than `MARK_SLOT` is written.
- R7: Running the exchange twice with the same offsets restores both buffers to their original contents.
- R8: A start accepted in idle follows a fixed sequence on consecutive cycles, beginning the cycle after the accepting edge:
  - read data[off], read data[off+1], read the spare slot;
  - write the spare slot, write data[off], write data[off+1];
  - one cycle of `done`, which therefore appears in the 7th cycle.
  A data read and a data write never coincide.
- R9: A `start` pulse while the unit is busy is ignored. The running exchange completes with its original offsets.
- R10: The address data[off+1] is formed as (off+1) modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one exchange (accepted only when idle) |
| byte_off | input | ADDR_W | Data byte holding the marker's first bit |
| bit_off | input | BIT_W | Bit position of the marker inside that byte |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| d_addr | output | ADDR_W | Data buffer address |
| d_rd | output | 1 | Data buffer read strobe |
| d_wr | output | 1 | Data buffer write strobe |
| d_wdata | output | BYTE_W | Data buffer write byte |
| d_rdata | input | BYTE_W | Data buffer read byte, one cycle after `d_rd` |
| s_addr | output | SPARE_AW | Spare buffer address |
| s_rd | output | 1 | Spare buffer read strobe |
| s_wr | output | 1 | Spare buffer write strobe |
| s_wdata | output | BYTE_W | Spare buffer write byte |
| s_rdata | input | BYTE_W | Spare buffer read byte, one cycle after `s_rd` |

## Verification
Some properties are checked every cycle:
- the port ordering after an accepted start;
- the exclusion of data reads and writes;
- the single-cycle `done` pulse;
- the frozen offsets while busy;
- the rule that an aligned exchange never touches the high byte;
- the stability of captured bytes during the write phase.

Other properties only the bench scenarios can show. These are the bit-exact merge results in both data bytes and the spare slot at every shift, the restoration after a double exchange, and the absence of writes to any other address. The bench shows them by comparing whole RAM images against bench-computed images.

// File: rtl/mark_swap_pkg.sv
package mark_swap_pkg;
   typedef enum logic [2:0] {
      MS_IDLE  = 3'd0,
      MS_RD_LO = 3'd1,
      MS_RD_HI = 3'd2,
      MS_RD_SP = 3'd3,
      MS_WR_SP = 3'd4,
      MS_WR_LO = 3'd5,
      MS_WR_HI = 3'd6,
      MS_DONE  = 3'd7
   } ms_state_e;
endpackage

// File: rtl/mark_swap_ctrl.sv
module mark_swap_ctrl
   import mark_swap_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int BIT_W        = 3,
   parameter int SPARE_AW     = 4,
   parameter int MARK_SLOT    = 0,
   parameter bit SKIP_ALIGNED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   byte_off,
   input  logic [BIT_W-1:0]    bit_off,
   output ms_state_e           state,
   output logic [BIT_W-1:0]    bit_q,
   output logic                busy,
   output logic                done,
   output logic [ADDR_W-1:0]   d_addr,
   output logic                d_rd,
   output logic                d_wr,
   output logic [SPARE_AW-1:0] s_addr,
   output logic                s_rd,
   output logic                s_wr
);
   localparam logic [SPARE_AW-1:0] SLOT = SPARE_AW'(MARK_SLOT);

   ms_state_e         state_q, state_d;
   logic [ADDR_W-1:0] off_q;
   logic [ADDR_W-1:0] off_nx;
   logic              hi_wr_en;

   assign off_nx = off_q + ADDR_W'(1);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MS_IDLE:  if (start) state_d = MS_RD_LO;
         MS_RD_LO: state_d = MS_RD_HI;
         MS_RD_HI: state_d = MS_RD_SP;
         MS_RD_SP: state_d = MS_WR_SP;
         MS_WR_SP: state_d = MS_WR_LO;
         MS_WR_LO: state_d = MS_WR_HI;
         MS_WR_HI: state_d = MS_DONE;
         MS_DONE:  state_d = MS_IDLE;
         default:  state_d = MS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MS_IDLE;
         off_q   <= '0;
         bit_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == MS_IDLE && start) begin
            off_q <= byte_off;
            bit_q <= bit_off;
         end
      end
   end

   generate
      if (SKIP_ALIGNED) begin : g_skip_aligned
         assign hi_wr_en = (bit_q != '0);
      end else begin : g_always_write
         assign hi_wr_en = 1'b1;
      end
   endgenerate

   assign state  = state_q;
   assign busy   = (state_q != MS_IDLE) && (state_q != MS_DONE);
   assign done   = (state_q == MS_DONE);
   assign d_rd   = (state_q == MS_RD_LO) || (state_q == MS_RD_HI);
   assign d_wr   = (state_q == MS_WR_LO) || ((state_q == MS_WR_HI) && hi_wr_en);
   assign d_addr = ((state_q == MS_RD_HI) || (state_q == MS_WR_HI)) ? off_nx : off_q;
   assign s_rd   = (state_q == MS_RD_SP);
   assign s_wr   = (state_q == MS_WR_SP);
   assign s_addr = SLOT;

   // R8: the accepted start leads straight into a read of the low byte
   p_start_reads_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MS_IDLE && start) |=> (d_rd && d_addr == $past(byte_off)));
   // R8: read and write on the data port never overlap
   p_port_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(d_rd && d_wr));
   // R8: done lasts a single cycle and follows the last write slot
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(state_q) == MS_WR_HI));
   // R9: latched offsets stay frozen while an exchange runs
   p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(off_q) && $stable(bit_q)));
   // R5: an aligned exchange leaves the high byte unwritten
   p_aligned_hi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (SKIP_ALIGNED && bit_q == '0 && state_q == MS_WR_HI) |-> !d_wr);
endmodule

// File: rtl/mark_swap_datapath.sv
module mark_swap_datapath
   import mark_swap_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int BIT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ms_state_e         state,
   input  logic [BIT_W-1:0]  bit_q,
   input  logic [BYTE_W-1:0] d_rdata,
   input  logic [BYTE_W-1:0] s_rdata,
   output logic [BYTE_W-1:0] d_wdata,
   output logic [BYTE_W-1:0] s_wdata
);
   localparam int PAIR_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_q, hi_q, sp_q;
   logic [PAIR_W-1:0] pair, pair_sh, keep_mask, ins, merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
         sp_q <= '0;
      end else begin
         if (state == MS_RD_HI) lo_q <= d_rdata;
         if (state == MS_RD_SP) hi_q <= d_rdata;
         if (state == MS_WR_SP) sp_q <= s_rdata;
      end
   end

   assign pair      = {hi_q, lo_q};
   assign pair_sh   = pair >> bit_q;
   assign keep_mask = ~({{BYTE_W{1'b0}}, {BYTE_W{1'b1}}} << bit_q);
   assign ins       = {{BYTE_W{1'b0}}, sp_q} << bit_q;
   assign merged    = (pair & keep_mask) | ins;

   assign s_wdata = pair_sh[BYTE_W-1:0];
   assign d_wdata = (state == MS_WR_HI) ? merged[PAIR_W-1:BYTE_W] : merged[BYTE_W-1:0];

   // R3 R4: the captured bytes hold steady across the write phase
   p_capture_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MS_WR_LO || state == MS_WR_HI) |-> ($stable(lo_q) && $stable(hi_q)));
   // R2: spare byte captured in the slot that writes the spare is kept for the data writes
   p_spare_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MS_WR_HI) |-> $stable(sp_q));
endmodule

// File: rtl/mark_swap_unit.sv
module mark_swap_unit
   import mark_swap_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int BYTE_W       = 8,
   parameter int SPARE_AW     = 4,
   parameter int MARK_SLOT    = 0,
   parameter bit SKIP_ALIGNED = 1'b1,
   localparam int BIT_W       = $clog2(BYTE_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   byte_off,
   input  logic [BIT_W-1:0]    bit_off,
   output logic                busy,
   output logic                done,
   output logic [ADDR_W-1:0]   d_addr,
   output logic                d_rd,
   output logic                d_wr,
   output logic [BYTE_W-1:0]   d_wdata,
   input  logic [BYTE_W-1:0]   d_rdata,
   output logic [SPARE_AW-1:0] s_addr,
   output logic                s_rd,
   output logic                s_wr,
   output logic [BYTE_W-1:0]   s_wdata,
   input  logic [BYTE_W-1:0]   s_rdata
);
   ms_state_e        state;
   logic [BIT_W-1:0] bit_q;

   initial begin
      assert (BYTE_W >= 2 && (1 << BIT_W) == BYTE_W)
         else $error("BYTE_W must be a power of two of at least 2");
      assert (ADDR_W >= 1) else $error("ADDR_W must be positive");
      assert (MARK_SLOT >= 0 && MARK_SLOT < (1 << SPARE_AW))
         else $error("MARK_SLOT outside the spare buffer");
   end

   mark_swap_ctrl #(
      .ADDR_W(ADDR_W), .BIT_W(BIT_W), .SPARE_AW(SPARE_AW),
      .MARK_SLOT(MARK_SLOT), .SKIP_ALIGNED(SKIP_ALIGNED)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_off(byte_off),
      .bit_off(bit_off), .state(state), .bit_q(bit_q), .busy(busy),
      .done(done), .d_addr(d_addr), .d_rd(d_rd), .d_wr(d_wr),
      .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr)
   );

   mark_swap_datapath #(
      .BYTE_W(BYTE_W), .BIT_W(BIT_W)
   ) i_dp (
      .clk(clk), .rst_n(rst_n), .state(state), .bit_q(bit_q),
      .d_rdata(d_rdata), .s_rdata(s_rdata),
      .d_wdata(d_wdata), .s_wdata(s_wdata)
   );

   // R6: the spare port only ever addresses the marker slot
   p_spare_slot_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rd || s_wr) |-> (s_addr == SPARE_AW'(MARK_SLOT)));
   // R1: no strobe while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done) |-> !(d_rd || d_wr || s_rd || s_wr));
endmodule

// File: tb/test_mark_swap_unit.sv
module test_mark_swap_unit;
   localparam int AW = 12;
   localparam int SAW = 4;
   localparam int DN = 1 << AW;
   localparam int SN = 1 << SAW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] byte_off = '0;
   logic [2:0] bit_off = '0;
   logic busy, done, d_rd, d_wr, s_rd, s_wr;
   logic [AW-1:0] d_addr;
   logic [SAW-1:0] s_addr;
   logic [7:0] d_wdata, s_wdata;
   logic [7:0] d_rdata = '0, s_rdata = '0;

   logic [7:0] dmem [DN];
   logic [7:0] smem [SN];
   logic [7:0] edm [DN];
   logic [7:0] esm [SN];

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   mark_swap_unit i_mark_swap_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_off(byte_off),
      .bit_off(bit_off), .busy(busy), .done(done), .d_addr(d_addr),
      .d_rd(d_rd), .d_wr(d_wr), .d_wdata(d_wdata), .d_rdata(d_rdata),
      .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr), .s_wdata(s_wdata),
      .s_rdata(s_rdata)
   );

   always @(posedge clk) begin
      if (d_rd) d_rdata <= dmem[d_addr];
      if (d_wr) dmem[d_addr] <= d_wdata;
      if (s_rd) s_rdata <= smem[s_addr];
      if (s_wr) smem[s_addr] <= s_wdata;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected exchange applied to the bench's own images, bit by bit
   task automatic model(input int off, input int b);
      int hi_a;
      logic [7:0] lo, hi, sp, view, nlo, nhi;
      hi_a = (off + 1) % DN;
      lo = edm[off]; hi = edm[hi_a]; sp = esm[0];
      for (int i = 0; i < 8; i++)
         view[i] = (b + i < 8) ? lo[b + i] : hi[b + i - 8];
      nlo = lo; nhi = hi;
      for (int i = 0; i < 8; i++) begin
         if (b + i < 8) nlo[b + i] = sp[i];
         else nhi[b + i - 8] = sp[i];
      end
      esm[0] = view;
      edm[off] = nlo;
      edm[hi_a] = nhi;
   endtask

   function automatic int image_diffs();
      int n = 0;
      for (int i = 0; i < DN; i++) if (dmem[i] !== edm[i]) n++;
      for (int i = 0; i < SN; i++) if (smem[i] !== esm[i]) n++;
      return n;
   endfunction

   // runs one exchange; returns cycles from accepting edge to done
   task automatic run(input int off, input int b, input bit poke_busy, output int lat,
                      output int hi_writes);
      lat = 0; hi_writes = 0;
      @(negedge clk);
      byte_off = AW'(off); bit_off = 3'(b); start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int n = 1; n <= 20; n++) begin
         if (d_wr && d_addr == AW'((off + 1) % DN)) hi_writes++;
         if (done) begin lat = n; break; end
         if (poke_busy && n == 2) begin
            byte_off = AW'(off + 5); bit_off = 3'(b + 3); start = 1'b1;
         end else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_op(input int off, input int b, input bit poke, input string tag);
      int lat, hw;
      model(off, b);
      run(off, b, poke, lat, hw);
      check({tag, " R8 latency"}, lat, 7);
      check({tag, " R2 R3 R4 R6 image"}, image_diffs(), 0);
      if (b == 0) check({tag, " R5 no hi write"}, hw, 0);
   endtask

   initial begin
      int seed;
      seed = 32'h5EED;
      void'($urandom(seed));
      for (int i = 0; i < DN; i++) begin dmem[i] = 8'($urandom); edm[i] = dmem[i]; end
      for (int i = 0; i < SN; i++) begin smem[i] = 8'($urandom); esm[i] = smem[i]; end
      #1;
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 strobes", {d_rd, d_wr, s_rd, s_wr}, 0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      check("R1 busy after release", busy, 0);

      // every shift, directed
      for (int b = 0; b < 8; b++) do_op(100 + 7 * b, b, 1'b0, "shift");
      // known-pattern corner: shift 3, all ones in data, zero spare
      @(negedge clk);
      dmem[50] = 8'hFF; dmem[51] = 8'hFF; smem[0] = 8'h00;
      edm[50] = 8'hFF; edm[51] = 8'hFF; esm[0] = 8'h00;
      do_op(50, 3, 1'b0, "pattern");
      check("R3 lo literal", dmem[50], 8'h07);
      check("R4 hi literal", dmem[51], 8'hF8);
      check("R2 spare literal", smem[0], 8'hFF);
      // wrap at the top of the data buffer
      do_op(DN - 1, 5, 1'b0, "R10 wrap");
      // start while busy is ignored
      do_op(300, 2, 1'b1, "R9 busy start");
      // involution: twice restores
      begin
         logic [7:0] a0, a1, s0;
         a0 = dmem[700]; a1 = dmem[701]; s0 = smem[0];
         do_op(700, 6, 1'b0, "R7 first");
         do_op(700, 6, 1'b0, "R7 second");
         check("R7 restore", {dmem[700], dmem[701], smem[0]}, {a0, a1, s0});
      end
      // random mix
      for (int k = 0; k < 40; k++)
         do_op(int'($urandom % DN), int'($urandom % 8), 1'b0, "random");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule